// File: doc/BRIEF.md
# Return Address Stack Predictor

This block watches the instruction stream as it issues in a RISC-V front end. It decides whether each issued instruction is a subroutine call, a subroutine return, or both. A call pushes its fall-through address onto a small stack. A return pops that stack.

The predicted return target is not read from the live stack top. It comes from a holding register that keeps the most recently popped address. When a pop finds the stack empty, the holding register is marked invalid. The block has no knowledge of branch outcomes and no recovery path. It only follows the issue stream it is shown.

The stack holds one entry fewer than the `DEPTH` parameter. When it is full, a new call pushes out the oldest entry without any indication.

Top module: `ras_predictor`

## Requirements
- R1: After `rst_ni` is asserted low, `pred_valid_o` is 0 and the stack is empty, so the first return issued after reset yields `pred_valid_o` = 0.
- R2: A 32-bit instruction (`compressed_i` = 0) is a return when all of these hold: opcode bits [6:0] = 1100111, funct3 bits [14:12] = 000, rs1 bits [19:15] is x1 or x5, and rs1 differs from rd bits [11:7]. The immediate is not examined. A compressed instruction is a return when all of these hold: bits [1:0] = 10, bits [15:13] = 100, bits [6:2] = 0, and the register in bits [11:7] is x1 or x5. Bit 12 does not matter for this test.
- R3: An instruction is a call in any of these cases: a compressed word with bits [1:0] = 01 and bits [15:13] = 001; a compressed register jump as in R2 with bit 12 = 1 and a nonzero register in bits [11:7]; a 32-bit jump (opcode 1101111) or register jump (opcode 1100111, funct3 000) whose rd is x1 or x5.
- R4: A call pushes `pc_i` + 2 when `compressed_i` = 1, and `pc_i` + 4 otherwise.
- R5: A return that finds the stack non-empty removes the newest entry. One cycle after the issue edge, `pred_valid_o` = 1 and `pred_target_o` equals that entry. Entries come out in last-in, first-out order.
- R6: A return that finds the stack empty sets `pred_valid_o` to 0 on the next cycle.
- R7: The stack holds `DEPTH`-1 entries. A call made while the stack is full discards the oldest entry, and that entry is never predicted afterwards.
- R8: An instruction that is both a return and a call first pops, then pushes, within the same issue. The prediction reflects the pop, and the pushed address becomes the new top. On an empty stack, the pop invalidates the prediction and the push still happens.
- R9: When `issue_valid_i` = 0, or when the issued instruction is neither a call nor a return, the stack and the prediction outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | An instruction issues this cycle |
| instr_i | input | 32 | Issued instruction word (compressed forms use bits [15:0]) |
| pc_i | input | XLEN | Address of the issued instruction |
| compressed_i | input | 1 | Issued instruction is 16 bits long |
| pred_valid_o | output | 1 | Predicted return target is valid |
| pred_target_o | output | XLEN | Most recently popped return address |

## Verification
Pop and push can occur in the same issue when a register jump both reads and writes a link register. Two such encodings produce this: a compressed jump-and-link through x1, and a 32-bit register jump from x5 into x1. The bench issues them both on a populated stack and on an empty one.

In the populated case, the outcome is judged by two things. The prediction on the following cycle must show the old top. A later return must then yield the freshly pushed address. In the empty case, the prediction must go invalid while the push still takes effect. A reference queue model then runs the same mix of overflow and underflow and is compared cycle by cycle.

// File: rtl/ras_pkg.sv
package ras_pkg;
  localparam logic [4:0] REG_RA   = 5'd1;
  localparam logic [4:0] REG_T0   = 5'd5;
  localparam logic [6:0] OP_JAL   = 7'b1101111;
  localparam logic [6:0] OP_JALR  = 7'b1100111;

  typedef struct packed {
    logic is_call;
    logic is_ret;
  } ctl_class_t;

  function automatic logic is_link(input logic [4:0] r);
    return (r == REG_RA) || (r == REG_T0);
  endfunction
endpackage

// File: rtl/ras_decode.sv
module ras_decode
  import ras_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic        compressed_i,
  output ctl_class_t  cls_o
);
  logic [4:0] rd, rs1, c_reg;
  logic       jal_w, jalr_w, c_jal, c_regjump, c_link;

  assign rd     = instr_i[11:7];
  assign rs1    = instr_i[19:15];
  assign c_reg  = instr_i[11:7];
  assign jal_w  = (instr_i[6:0] == OP_JAL);
  assign jalr_w = (instr_i[6:0] == OP_JALR) && (instr_i[14:12] == 3'b000);

  assign c_jal     = (instr_i[1:0] == 2'b01) && (instr_i[15:13] == 3'b001);
  assign c_regjump = (instr_i[1:0] == 2'b10) && (instr_i[15:13] == 3'b100) &&
                     (instr_i[6:2] == 5'd0) && (c_reg != 5'd0);
  assign c_link    = c_regjump && instr_i[12];

  always_comb begin
    cls_o = '0;
    if (compressed_i) begin
      // compressed returns skip the rs1 != rd test
      cls_o.is_ret  = c_regjump && is_link(c_reg);
      cls_o.is_call = c_jal || c_link;
    end else begin
      cls_o.is_ret  = jalr_w && is_link(rs1) && (rs1 != rd);
      cls_o.is_call = (jal_w || jalr_w) && is_link(rd);
    end
  end
endmodule

// File: rtl/ras_stack.sv
module ras_stack #(
  parameter int XLEN = 32,
  parameter int LIVE = 1,
  localparam int CW  = $clog2(LIVE + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pop_i,
  input  logic            push_i,
  input  logic [XLEN-1:0] push_addr_i,
  output logic            pop_hit_o,
  output logic [XLEN-1:0] top_o,
  output logic [CW-1:0]   count_o
);
  localparam logic [CW-1:0] FULL = CW'(LIVE);

  logic [XLEN-1:0] ent_q [LIVE];
  logic [CW-1:0]   count_q, cnt_popped, cnt_next;

  assign pop_hit_o = pop_i && (count_q != '0);
  assign top_o     = ent_q[0];
  assign count_o   = count_q;

  always_comb begin
    cnt_popped = pop_hit_o ? count_q - CW'(1) : count_q;
    cnt_next   = cnt_popped;
    if (push_i && (cnt_popped != FULL)) cnt_next = cnt_popped + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= cnt_next;
  end

  for (genvar g = 0; g < LIVE; g++) begin : g_ent
    logic [XLEN-1:0] from_newer, from_older;
    if (g == 0) begin : g_head
      assign from_newer = push_addr_i;
    end else begin : g_body
      assign from_newer = ent_q[g-1];
    end
    if (g == LIVE - 1) begin : g_tail
      assign from_older = '0;
    end else begin : g_mid
      assign from_older = ent_q[g+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[g] <= '0;
      end else if (push_i && pop_i) begin
        // pop then push: only the top slot is replaced
        if (g == 0) ent_q[g] <= push_addr_i;
      end else if (push_i) begin
        ent_q[g] <= from_newer;   // oldest falls off the tail
      end else if (pop_hit_o) begin
        ent_q[g] <= from_older;
      end
    end
  end
endmodule

// File: rtl/ras_hold.sv
module ras_hold #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pop_i,
  input  logic            pop_hit_i,
  input  logic [XLEN-1:0] pop_data_i,
  output logic            valid_o,
  output logic [XLEN-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (pop_i) begin
      valid_o <= pop_hit_i;
      data_o  <= pop_hit_i ? pop_data_i : '0;
    end
  end
endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
  import ras_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int DEPTH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            compressed_i,
  output logic            pred_valid_o,
  output logic [XLEN-1:0] pred_target_o
);
  localparam int LIVE = DEPTH - 1;
  localparam int CW   = $clog2(LIVE + 1);

  ctl_class_t      cls;
  logic            dec_call, dec_ret, do_pop, do_push, pop_hit;
  logic [XLEN-1:0] next_pc, stk_top;
  logic [CW-1:0]   stk_count;

  ras_decode u_dec (
    .instr_i      (instr_i),
    .compressed_i (compressed_i),
    .cls_o        (cls)
  );

  assign dec_call = cls.is_call;
  assign dec_ret  = cls.is_ret;
  assign do_pop   = issue_valid_i && dec_ret;
  assign do_push  = issue_valid_i && dec_call;
  assign next_pc  = pc_i + (compressed_i ? XLEN'(2) : XLEN'(4));

  ras_stack #(.XLEN(XLEN), .LIVE(LIVE)) u_stk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pop_i       (do_pop),
    .push_i      (do_push),
    .push_addr_i (next_pc),
    .pop_hit_o   (pop_hit),
    .top_o       (stk_top),
    .count_o     (stk_count)
  );

  ras_hold #(.XLEN(XLEN)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pop_i      (do_pop),
    .pop_hit_i  (pop_hit),
    .pop_data_i (stk_top),
    .valid_o    (pred_valid_o),
    .data_o     (pred_target_o)
  );
endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
  parameter int XLEN = 32,
  parameter int LIVE = 1,
  localparam int CW  = $clog2(LIVE + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            issue_valid_i,
  input logic [XLEN-1:0] pc_i,
  input logic            compressed_i,
  input logic            call_i,
  input logic            ret_i,
  input logic [CW-1:0]   count_i,
  input logic [XLEN-1:0] top_i,
  input logic            pred_valid_i,
  input logic [XLEN-1:0] pred_target_i
);
  a_r9_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_i |=> $stable(pred_valid_i) && $stable(pred_target_i) && $stable(count_i));

  a_r9_no_ret_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i && !ret_i |=> $stable(pred_valid_i) && $stable(pred_target_i));

  a_r7_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(LIVE));

  a_r7_full_stays_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i && call_i && !ret_i && (count_i == CW'(LIVE)) |=> count_i == CW'(LIVE));

  a_r4_push_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i && call_i |=>
      top_i == $past(pc_i) + ($past(compressed_i) ? XLEN'(2) : XLEN'(4)));

  a_r5_pop_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i && ret_i && (count_i != '0) |=> pred_valid_i && (pred_target_i == $past(top_i)));

  a_r6_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i && ret_i && (count_i == '0) |=> !pred_valid_i);

  a_r8_pop_push_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i && ret_i && call_i && (count_i != '0) |=> count_i == $past(count_i));
endmodule

bind ras_predictor ras_checker #(.XLEN(XLEN), .LIVE(DEPTH - 1)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_valid_i (issue_valid_i),
  .pc_i          (pc_i),
  .compressed_i  (compressed_i),
  .call_i        (dec_call),
  .ret_i         (dec_ret),
  .count_i       (stk_count),
  .top_i         (stk_top),
  .pred_valid_i  (pred_valid_o),
  .pred_target_i (pred_target_o)
);

// File: tb/sim_ras_predictor.sv
module sim_ras_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN  = 32;
  localparam int DEPTH = 4;
  localparam int LIVE  = DEPTH - 1;
  localparam int NVEC  = 20;

  typedef struct packed {
    logic        vld;
    logic        comp;
    logic [31:0] instr;
    logic [31:0] pc;
    logic        exp_v;
    logic [31:0] exp_t;
    logic [3:0]  req;
  } vec_t;

  // stack shown newest first; capacity 3
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b0, 32'h0000_00EF, 32'h100, 1'b0, 32'h0,   4'd4}, // R4 jal ra -> [104]
    '{1'b1, 1'b1, 32'h0000_2001, 32'h200, 1'b0, 32'h0,   4'd3}, // R3 c.jal -> [202,104]
    '{1'b1, 1'b1, 32'h0000_9502, 32'h300, 1'b0, 32'h0,   4'd3}, // R3 c.jalr a0 -> [302,202,104]
    '{1'b1, 1'b0, 32'h0000_02EF, 32'h400, 1'b0, 32'h0,   4'd7}, // R7 jal t0, 104 dropped
    '{1'b1, 1'b0, 32'h0000_8067, 32'h500, 1'b1, 32'h404, 4'd5}, // R5 ret
    '{1'b1, 1'b0, 32'h0100_8067, 32'h504, 1'b1, 32'h302, 4'd2}, // R2 ret with imm
    '{1'b1, 1'b0, 32'h0001_0067, 32'h508, 1'b1, 32'h302, 4'd2}, // R2 jr x2: no pop
    '{1'b1, 1'b0, 32'h0000_80E7, 32'h600, 1'b1, 32'h302, 4'd2}, // R2 rs1==rd: call only
    '{1'b1, 1'b1, 32'h0000_8282, 32'h604, 1'b1, 32'h604, 4'd2}, // R2 c.jr t0
    '{1'b1, 1'b0, 32'h0002_80E7, 32'h700, 1'b1, 32'h202, 4'd8}, // R8 jalr ra,t0 -> [704]
    '{1'b1, 1'b1, 32'h0000_9082, 32'h800, 1'b1, 32'h704, 4'd8}, // R8 c.jalr ra -> [802]
    '{1'b1, 1'b1, 32'h0000_8502, 32'h802, 1'b1, 32'h704, 4'd2}, // R2 c.jr a0: no pop
    '{1'b1, 1'b0, 32'h0000_0013, 32'h804, 1'b1, 32'h704, 4'd9}, // R9 nop
    '{1'b1, 1'b1, 32'h0000_8082, 32'h808, 1'b1, 32'h802, 4'd5}, // R5 c.jr ra -> []
    '{1'b1, 1'b0, 32'h0000_8067, 32'h80C, 1'b0, 32'h0,   4'd6}, // R6 ret on empty
    '{1'b1, 1'b0, 32'h0000_006F, 32'h900, 1'b0, 32'h0,   4'd3}, // R3 jal x0: no push
    '{1'b1, 1'b1, 32'h0000_9082, 32'hA00, 1'b0, 32'h0,   4'd8}, // R8 on empty -> [A02]
    '{1'b1, 1'b0, 32'h0000_8067, 32'hA04, 1'b1, 32'hA02, 4'd8}, // R8 pushed value popped
    '{1'b0, 1'b0, 32'h0000_00EF, 32'hB00, 1'b1, 32'hA02, 4'd9}, // R9 valid low: ignored
    '{1'b1, 1'b0, 32'h0000_8067, 32'hB04, 1'b0, 32'h0,   4'd9}  // R9 nothing was pushed
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            issue_valid = 1'b0;
  logic [31:0]     instr = '0;
  logic [XLEN-1:0] pc = '0;
  logic            comp = 1'b0;
  logic            pred_valid;
  logic [XLEN-1:0] pred_target;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] ref_q [$];
  logic        ref_v = 1'b0;
  logic [31:0] ref_t = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ras_predictor #(.XLEN(XLEN), .DEPTH(DEPTH)) u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .issue_valid_i (issue_valid),
    .instr_i       (instr),
    .pc_i          (pc),
    .compressed_i  (comp),
    .pred_valid_o  (pred_valid),
    .pred_target_o (pred_target)
  );

  task automatic check(input string tag, input logic ev, input logic [31:0] et);
    checks++;
    if (pred_valid !== ev || (ev && pred_target !== et)) begin
      failures++;
      $display("FAIL %s: got valid=%0b target=%h, expected valid=%0b target=%h",
               tag, pred_valid, pred_target, ev, et);
    end
  endtask

  task automatic issue(input logic v, input logic c, input logic [31:0] w, input logic [31:0] a);
    issue_valid = v; comp = c; instr = w; pc = a;
    @(posedge clk); #1;
    issue_valid = 1'b0;
  endtask

  task automatic ref_call(input logic [31:0] a);
    issue(1'b1, 1'b0, 32'h0000_00EF, a);
    ref_q.push_back(a + 32'd4);
    if (ref_q.size() > LIVE) void'(ref_q.pop_front());
  endtask

  task automatic ref_ret();
    issue(1'b1, 1'b0, 32'h0000_8067, 32'h0);
    if (ref_q.size() > 0) begin ref_v = 1'b1; ref_t = ref_q.pop_back(); end
    else begin ref_v = 1'b0; ref_t = '0; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 1'b0, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", 1'b0, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i].vld, VEC[i].comp, VEC[i].instr, VEC[i].pc);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp_v, VEC[i].exp_t);
    end

    // R1: reset mid-stream empties stack and invalidates prediction
    issue(1'b1, 1'b0, 32'h0000_00EF, 32'hC00);
    issue(1'b1, 1'b0, 32'h0000_00EF, 32'hC10);
    issue(1'b1, 1'b0, 32'h0000_8067, 32'hC20);
    check("R5 before reset", 1'b1, 32'hC14);
    rst_n = 1'b0; #2;
    check("R1 async reset", 1'b0, 32'h0);
    @(posedge clk); #1; rst_n = 1'b1;
    issue(1'b1, 1'b0, 32'h0000_8067, 32'hC30);
    check("R1 stack emptied", 1'b0, 32'h0);

    // R7/R6 against reference queue: overflow then underflow
    ref_q.delete(); ref_v = 1'b0;
    for (int k = 0; k < 5; k++) ref_call(32'h1000 + 32'h10 * k);
    for (int k = 0; k < 5; k++) begin
      ref_ret();
      check($sformatf("R7 ref pop %0d", k), ref_v, ref_t);
    end

    // R8: mixed pop/push against reference
    ref_call(32'h2000);
    issue(1'b1, 1'b0, 32'h0002_80E7, 32'h2100);
    check("R8 pop-push prediction", 1'b1, 32'h2004);
    ref_ret();
    check("R8 pushed becomes top", 1'b1, 32'h2104);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule